// File: doc/BRIEF.md
# Rotation-Fed Systolic Multiplier over an All-One-Polynomial Field

This block multiplies two elements of a binary extension field whose reduction polynomial is the all-one polynomial of degree DEG. Here DEG+1 must be prime and 2 must be a primitive root modulo DEG+1. Both operands and the result use a redundant basis of DEG+1 coefficients. Because x^(DEG+1) = 1 in that basis, multiplying by x is a plain cyclic rotation of the coefficient vector. The product is therefore the cyclic convolution of the two coefficient vectors.

The datapath is a linear chain of processing stages. A stage ANDs one coefficient of B with a fixed rotation of A and XORs the result into the running sum from the stage before. It then registers the new sum. Every stage takes its rotation of A straight from the input pins over fixed wiring, so no register carries A down the chain. Only the partial sum and the B coefficients that later stages still need are registered. A parameter can merge two neighbouring stages into one registered stage, which roughly halves the latency. A second parameter builds the gates as NAND/XNOR pairs.

A user pulses `start` with A and B on the inputs. A must stay unchanged until `outValid` reports the product. B is needed only in the cycle the start is accepted. The block works on one product at a time.

Top module: `aop_mult`

## Requirements
- R1: When `outValid` is high, `cOut` bit m equals the XOR, over every index pair (i, j) with (i + j) mod (DEG+1) = m, of `aIn[j]` AND `bIn[i]`. This holds for all DEG+1 bits of both operands, including nonzero top bits.
- R2: With DIGIT = 2, the result is the same as in R1, and the stage count is ceil((DEG+1)/2).
- R3: `outValid` is high for exactly one cycle, NUM_STAGE clock edges after the edge that accepts a start. NUM_STAGE is DEG+1 when DIGIT = 1.
- R4: B is sampled only at the accepting edge. Changes on `bIn` after that edge do not affect the result.
- R5: A start that arrives while a product is in flight is ignored and produces no extra `outValid`. This includes the cycle in which `outValid` is high. A start held high is accepted again in the cycle after the result.
- R6: After a result, `cOut` keeps its value until the next start is accepted.
- R7: While `rstN` is low, `outValid` is 0 and `cOut` is all zeros.
- R8: With INV_GATES = 1, the NAND/XNOR gate variant gives results identical to R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a product; accepted only when idle |
| aIn | input | DEG+1 | Operand A; must stay stable until `outValid` |
| bIn | input | DEG+1 | Operand B; sampled at the accepting edge |
| outValid | output | 1 | One-cycle strobe marking a finished product |
| cOut | output | DEG+1 | Product coefficients |

## Verification
The in-line assertions check on every cycle that:
- at most one product is in flight;
- each `outValid` falls exactly NUM_STAGE edges after its accept, measured by an independent counter;
- the first registered B slice matches the `bIn` seen at the accept;
- `cOut` does not move while the chain is idle.

Only the bench scenarios can show that the arithmetic is correct:
- the value is the cyclic convolution for every operand pair, in both the single-stage and merged-stage builds with both gate styles;
- changing B after an accept has no effect;
- starts poked mid-flight, or held high back to back, are dropped or accepted at the right cycle.

// File: rtl/aop_pkg.sv
package aop_pkg;

  // Strobes from the sequencer to the arithmetic chain.
  typedef struct packed {
    logic accept;  // a new product enters stage 0 this cycle
    logic run;     // chain registers advance this cycle
  } aopCtrl_t;

  // Number of registered stages when DIGIT coefficients share one stage.
  function automatic int stageCount(input int width, input int digit);
    return (width + digit - 1) / digit;
  endfunction

endpackage

// File: rtl/aop_ctrl.sv
module aop_ctrl
  import aop_pkg::*;
#(
  parameter int NUM_STAGE = 5
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output aopCtrl_t ctrl,
  output logic     outValid
);

  localparam int LCW = $clog2(NUM_STAGE + 2);

  // One marker bit per stage showing where the live product sits.
  logic [NUM_STAGE-1:0] vPipe;
  logic                 inFlight;

  assign inFlight    = |vPipe;
  assign ctrl.accept = start & ~inFlight;
  assign ctrl.run    = ctrl.accept | (|vPipe[NUM_STAGE-2:0]);
  assign outValid    = vPipe[NUM_STAGE-1];

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[NUM_STAGE-2:0], ctrl.accept};
  end

  // Independent cycle counter used only for the latency check.
  logic [LCW-1:0] latCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                           latCnt <= '0;
    else if (ctrl.accept)                                latCnt <= LCW'(1);
    else if (latCnt != '0 && latCnt <= LCW'(NUM_STAGE))  latCnt <= latCnt + LCW'(1);
  end

  assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vPipe));

  assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (latCnt == LCW'(NUM_STAGE)));

endmodule

// File: rtl/aop_datapath.sv
module aop_datapath
  import aop_pkg::*;
#(
  parameter int WIDTH     = 5,
  parameter int DIGIT     = 1,
  parameter int INV_GATES = 0,
  parameter int NUM_STAGE = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  aopCtrl_t         ctrl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] cOut
);

  // Gated partial product: one B coefficient against a rotated A.
  function automatic logic [WIDTH-1:0] mulBit(input logic [WIDTH-1:0] v, input logic s);
    if (INV_GATES != 0) return ~(~(v & {WIDTH{s}}));
    else                return v & {WIDTH{s}};
  endfunction

  // Coefficient-wise sum over GF(2).
  function automatic logic [WIDTH-1:0] addBits(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    if (INV_GATES != 0) return ~(x ~^ y);
    else                return x ^ y;
  endfunction

  // A multiplied by x^i is a left rotation by i; fixed wiring, no registers.
  logic [WIDTH-1:0] rotA [WIDTH];
  for (genvar i = 0; i < WIDTH; i++) begin : g_rot
    if (i == 0) begin : g_id
      assign rotA[i] = aIn;
    end else begin : g_sh
      assign rotA[i] = (aIn << i) | (aIn >> (WIDTH - i));
    end
  end

  for (genvar e = 0; e < NUM_STAGE; e++) begin : g_elem
    localparam int REM = WIDTH - e * DIGIT;   // B coefficients still needed here and later

    logic [REM-1:0]   bSrc;
    logic [WIDTH-1:0] sumIn;
    logic [WIDTH-1:0] part [DIGIT+1];
    logic [WIDTH-1:0] sumReg;

    if (e == 0) begin : g_head
      assign bSrc  = bIn;
      assign sumIn = '0;
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN)         bSrc <= '0;
        else if (ctrl.run) bSrc <= g_elem[e-1].bSrc[REM+DIGIT-1:DIGIT];
      end
      assign sumIn = g_elem[e-1].sumReg;
    end

    assign part[0] = sumIn;
    for (genvar d = 0; d < DIGIT; d++) begin : g_dig
      localparam int IDX = e * DIGIT + d;
      if (IDX < WIDTH) begin : g_use
        assign part[d+1] = addBits(part[d], mulBit(rotA[IDX], bSrc[d]));
      end else begin : g_skip
        assign part[d+1] = part[d];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)         sumReg <= '0;
      else if (ctrl.run) sumReg <= part[DIGIT];
    end
  end

  assign cOut = g_elem[NUM_STAGE-1].sumReg;

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> $stable(cOut));

  assert_b_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accept |=> (g_elem[1].bSrc == $past(bIn[WIDTH-1:DIGIT])));

endmodule

// File: rtl/aop_mult.sv
module aop_mult
  import aop_pkg::*;
#(
  parameter int DEG       = 4,
  parameter int DIGIT     = 1,
  parameter int INV_GATES = 0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [DEG:0] aIn,
  input  logic [DEG:0] bIn,
  output logic         outValid,
  output logic [DEG:0] cOut
);

  localparam int WIDTH     = DEG + 1;
  localparam int NUM_STAGE = stageCount(WIDTH, DIGIT);

  aopCtrl_t ctrl;

  aop_ctrl #(
    .NUM_STAGE(NUM_STAGE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  aop_datapath #(
    .WIDTH    (WIDTH),
    .DIGIT    (DIGIT),
    .INV_GATES(INV_GATES),
    .NUM_STAGE(NUM_STAGE)
  ) u_dp (
    .clk (clk),
    .rstN(rstN),
    .ctrl(ctrl),
    .aIn (aIn),
    .bIn (bIn),
    .cOut(cOut)
  );

  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rstN |=> (!outValid && cOut == '0));

endmodule

// File: tb/sim_aop_mult.sv
module sim_aop_mult;

  localparam int DEG  = 4;
  localparam int W    = DEG + 1;
  localparam int LAT0 = W;            // one coefficient per stage
  localparam int LAT1 = (W + 1) / 2;  // two coefficients per stage

  logic clk = 1'b0;
  always #10 clk = ~clk;              // 50 MHz

  logic         rstN  = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] aIn   = '0;
  logic [W-1:0] bIn   = '0;
  logic         ov0, ov1;
  logic [W-1:0] c0, c1;

  aop_mult #(.DEG(DEG), .DIGIT(1), .INV_GATES(0)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .aIn(aIn), .bIn(bIn),
    .outValid(ov0), .cOut(c0));

  aop_mult #(.DEG(DEG), .DIGIT(2), .INV_GATES(1)) u1 (
    .clk(clk), .rstN(rstN), .start(start), .aIn(aIn), .bIn(bIn),
    .outValid(ov1), .cOut(c1));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Product by definition: cyclic convolution modulo x^W + 1.
  function automatic logic [W-1:0] conv(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++)
        if (a[j] && b[i]) r[(i + j) % W] ^= 1'b1;
    return r;
  endfunction

  // Behavioural model: countdown per instance, expected result per instance.
  int           cnt0 = 0, cnt1 = 0;
  logic [W-1:0] exp0 = '0, exp1 = '0;
  bit           have0 = 1'b0, have1 = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      cnt0 <= 0; cnt1 <= 0; have0 <= 1'b0; have1 <= 1'b0;
    end else begin
      if (cnt0 == 0 && start) begin cnt0 <= LAT0; exp0 <= conv(aIn, bIn); end
      else if (cnt0 > 0) cnt0 <= cnt0 - 1;
      if (cnt0 == 1) have0 <= 1'b1;
      if (cnt1 == 0 && start) begin cnt1 <= LAT1; exp1 <= conv(aIn, bIn); end
      else if (cnt1 > 0) cnt1 <= cnt1 - 1;
      if (cnt1 == 1) have1 <= 1'b1;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(ov0 === (cnt0 == 1), "R3 R5 u0 outValid", W'(ov0), W'(cnt0 == 1));
      chk(ov1 === (cnt1 == 1), "R3 R5 u1 outValid", W'(ov1), W'(cnt1 == 1));
      if (cnt0 == 1) chk(c0 === exp0, "R1 R4 R5 u0 product", c0, exp0);
      if (cnt1 == 1) chk(c1 === exp1, "R2 R8 R4 u1 product", c1, exp1);
      if (cnt0 == 0 && have0) chk(c0 === exp0, "R6 u0 hold", c0, exp0);
      if (cnt1 == 0 && have1) chk(c1 === exp1, "R6 u1 hold", c1, exp1);
    end
  end

  task automatic waitIdle();
    while (cnt0 != 0 || cnt1 != 0) @(negedge clk);
  endtask

  // mode 0: plain; 1: poke start early in flight; 2: poke start while u0 reports.
  task automatic mul(input logic [W-1:0] a, input logic [W-1:0] b, input int mode);
    @(negedge clk);
    aIn = a; bIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bIn = ~b;                                  // R4: late B change must not matter
    if (mode == 1) begin
      start = 1'b1; bIn = W'($urandom);
      @(negedge clk);
      start = 1'b0;
    end else if (mode == 2) begin
      while (cnt0 != 1) @(negedge clk);
      start = 1'b1; bIn = W'($urandom);        // R5: ignored by u0
      @(negedge clk);
      start = 1'b0;
    end
    waitIdle();
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ov0 === 1'b0 && c0 === '0, "R7 u0 reset", c0, '0);
    chk(ov1 === 1'b0 && c1 === '0, "R7 u1 reset", c1, '0);
    rstN = 1'b1;

    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        mul(W'(a), W'(b), (a + b) % 3);

    // R5: start held high, B changing every cycle, A fixed.
    @(negedge clk);
    aIn = W'($urandom); start = 1'b1;
    for (int n = 0; n < 24; n++) begin
      bIn = W'($urandom);
      @(negedge clk);
    end
    start = 1'b0;
    waitIdle();

    for (int n = 0; n < 300; n++)
      mul(W'($urandom), W'($urandom), n % 3);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule